// File: doc/BRIEF.md
# Multi-Lane Serial Register Port

This block is the slave side of a serial control port. It reads and writes a small set of control registers. An external master selects the port by pulling an active-low select. The master then clocks an instruction byte followed by data bytes. The data moves over one, two or four data lanes, so that the same serial clock can carry more data per edge when lanes are added. Several ports can share one bus, because a port ignores all traffic while its select is high.

All port inputs are sampled by the on-chip system clock, and the edges of the serial clock are found in that clock domain. The port captures data on rising serial-clock edges. It updates its readback lanes on falling edges. Values written to the frequency, phase and amplitude registers go into buffer registers, and readback returns those buffer values. The active copies that feed the rest of the chip take the buffer contents only when the update strobe is high. The port's own lane-mode register is the one exception: it is written directly.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset, the active frequency, phase and amplitude outputs are zero, all lane enables are low, and the lane mode is one lane.
- R2: The first byte of a transaction is the instruction. Bit 7 set means read and bit 7 clear means write. Bits 4:0 are the register address, and bits 6:5 are ignored.
- R3: Bits 1:0 of register 0 set the lane mode: 00 uses lane 0 only, 01 uses lanes 0 and 1, and 10 or 11 uses all four lanes. A new mode applies to every byte of transactions that start after the write that sets it.
- R4: Each rising serial-clock edge moves one group of bits, with lane 0 carrying the most significant bit of the group. Bytes and multi-byte values travel most significant bit first.
- R5: The register sizes are as follows. Address 0 is 1 byte and holds the lane mode. Address 1 is the frequency word, FW/8 bytes (4 by default). Address 2 is the phase word, PW/8 bytes (2 by default). Address 3 is the amplitude word, AW/8 bytes (2 by default).
- R6: A write to address 1, 2 or 3 changes only the buffer register, and readback returns the buffer value. The active outputs keep their value until a clock cycle with update high, which copies every buffer to its active output.
- R7: Readback groups are driven after falling serial-clock edges. The first group follows the falling edge after the last instruction edge. Only the lanes of the current mode are enabled.
- R8: Raising the select in the middle of a transaction aborts it. A partially received value is discarded, no register changes, and the lane enables go low.
- R9: Once the last data bit has been clocked, further serial-clock edges are ignored until the select goes high. After a read, the lane enables go low at the rising edge that moves the last group.
- R10: Addresses 4 to 31 take one data byte. Writes to them are ignored, and reads from them return zero.
- R11: Serial-clock edges and lane data are ignored while the select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample every port input |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low port select from the master |
| sclk | input | 1 | Serial clock from the master |
| sdio_i | input | 4 | Lane input values |
| update | input | 1 | When high, copies all buffers to the active outputs |
| sdio_o | output | 4 | Lane readback values |
| sdio_oe | output | 4 | Per-lane output enable |
| freq_o | output | FW | Active frequency word |
| phase_o | output | PW | Active phase word |
| amp_o | output | AW | Active amplitude word |

## Verification
A wrong bit count or group order corrupts every value that is read back. The readback mismatch shows up within one write/read pair in the affected lane mode. A wrong lane mode also shows at once in the pattern of lane enables during the first readback group. A state machine that leaves a transaction too early or too late shows up in one of two ways. Either a write reaches a register after an abort or after the last byte, which is found on the next readback. Or the lane enables are still high when the select is raised, which is visible a few system clocks after the edge. Buffer-versus-active errors show on the active outputs one cycle after an update strobe, or as an early change before any strobe.

// File: rtl/serial_ctl_port.sv
module serial_ctl_port #(
  parameter int FW = 32,
  parameter int PW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic [3:0]    sdio_i,
  input  logic          update,
  output logic [3:0]    sdio_o,
  output logic [3:0]    sdio_oe,
  output logic [FW-1:0] freq_o,
  output logic [PW-1:0] phase_o,
  output logic [AW-1:0] amp_o
);
  localparam int MAXW = 32;
  localparam logic [5:0] FBITS = 6'(FW);
  localparam logic [5:0] PBITS = 6'(PW);
  localparam logic [5:0] ABITS = 6'(AW);

  typedef enum logic [1:0] {ST_INSTR, ST_WDATA, ST_RDATA, ST_DONE} st_t;

  logic [5:0]      s1;
  logic            sclk_d;
  st_t             st_q;
  logic [5:0]      left_q;
  logic [4:0]      addr_q;
  logic [MAXW-1:0] sh_q, rd_q, sh_nx;
  logic [7:0]      cfg_q;
  logic [FW-1:0]   buf_f;
  logic [PW-1:0]   buf_p;
  logic [AW-1:0]   buf_a;
  logic [3:0]      grp;

  wire       cs_hi = s1[5];
  wire       rise  = s1[4] & ~sclk_d;
  wire       fall  = ~s1[4] & sclk_d;
  wire [2:0] step  = cfg_q[1] ? 3'd4 : (cfg_q[0] ? 3'd2 : 3'd1);
  wire       last  = (left_q == {3'b000, step});

  always_comb begin
    if (cfg_q[1])      grp = {s1[0], s1[1], s1[2], s1[3]};
    else if (cfg_q[0]) grp = {2'b00, s1[0], s1[1]};
    else               grp = {3'b000, s1[0]};
    sh_nx = (sh_q << step) | {28'b0, grp};
  end

  function automatic logic [5:0] nbits(input logic [4:0] a);
    case (a)
      5'd1:    return FBITS;
      5'd2:    return PBITS;
      5'd3:    return ABITS;
      default: return 6'd8;
    endcase
  endfunction

  function automatic logic [MAXW-1:0] rdval(input logic [4:0] a);
    case (a)
      5'd0:    return {cfg_q, 24'b0};
      5'd1:    return MAXW'(buf_f) << (MAXW - FW);
      5'd2:    return MAXW'(buf_p) << (MAXW - PW);
      5'd3:    return MAXW'(buf_a) << (MAXW - AW);
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 6'b100000; sclk_d <= 1'b0;
      st_q <= ST_INSTR; left_q <= 6'd8; addr_q <= '0;
      sh_q <= '0; rd_q <= '0; cfg_q <= '0;
      buf_f <= '0; buf_p <= '0; buf_a <= '0;
      freq_o <= '0; phase_o <= '0; amp_o <= '0;
      sdio_o <= '0; sdio_oe <= '0;
    end else begin
      s1 <= {cs_n, sclk, sdio_i};
      sclk_d <= s1[4];
      if (update) begin
        freq_o <= buf_f; phase_o <= buf_p; amp_o <= buf_a;
      end
      if (cs_hi) begin
        st_q <= ST_INSTR; left_q <= 6'd8; sh_q <= '0; sdio_oe <= '0;
      end else if (rise && st_q != ST_DONE) begin
        sh_q   <= sh_nx;
        left_q <= left_q - {3'b000, step};
        if (last) begin
          case (st_q)
            ST_INSTR: begin
              addr_q <= sh_nx[4:0];
              left_q <= nbits(sh_nx[4:0]);
              rd_q   <= rdval(sh_nx[4:0]);
              st_q   <= sh_nx[7] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: begin
              case (addr_q)
                5'd0: cfg_q <= sh_nx[7:0];
                5'd1: buf_f <= sh_nx[FW-1:0];
                5'd2: buf_p <= sh_nx[PW-1:0];
                5'd3: buf_a <= sh_nx[AW-1:0];
                default: ;
              endcase
              st_q <= ST_DONE;
            end
            default: begin
              st_q <= ST_DONE; sdio_oe <= '0;
            end
          endcase
        end
      end else if (fall && st_q == ST_RDATA) begin
        rd_q <= rd_q << step;
        if (cfg_q[1]) begin
          sdio_o <= {rd_q[28], rd_q[29], rd_q[30], rd_q[31]}; sdio_oe <= 4'b1111;
        end else if (cfg_q[0]) begin
          sdio_o <= {2'b00, rd_q[30], rd_q[31]}; sdio_oe <= 4'b0011;
        end else begin
          sdio_o <= {3'b000, rd_q[31]}; sdio_oe <= 4'b0001;
        end
      end
    end
  end

  p_oe_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (sdio_oe == 4'b0000));
  p_oe_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe == 4'b0000) || (sdio_oe == 4'b0001) || (sdio_oe == 4'b0011) || (sdio_oe == 4'b1111));
  p_oe_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe != 4'b0000) |-> (st_q == ST_RDATA));
  p_drive_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdio_o));
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> ($stable(freq_o) && $stable(phase_o) && $stable(amp_o)));
  p_idle_when_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (st_q == ST_INSTR && left_q == 6'd8));
endmodule

// File: tb/tb_serial_ctl_port.sv
module tb_serial_ctl_port;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, update = 1'b0;
  logic [3:0] sdio_i = '0;
  logic [3:0] sdio_o, sdio_oe;
  logic [31:0] freq_o;
  logic [15:0] phase_o, amp_o;
  int checks = 0, failures = 0, lanes = 1;
  bit finished = 0;
  logic [7:0] m_cfg = '0;
  logic [31:0] m_f = '0;
  logic [15:0] m_p = '0, m_a = '0;

  always #4 clk = ~clk;

  serial_ctl_port dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .update(update), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .freq_o(freq_o), .phase_o(phase_o),
    .amp_o(amp_o));

  localparam logic [36:0] VEC [8] = '{
    {5'd1, 32'h12345678}, {5'd2, 32'h0000BEEF}, {5'd3, 32'h00000A5C}, {5'd1, 32'hF0E1D2C3},
    {5'd2, 32'h00000001}, {5'd3, 32'h00008000}, {5'd1, 32'h00000001}, {5'd9, 32'h0000005A}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [4:0] a);
    case (a) 5'd1: return 4; 5'd2, 5'd3: return 2; default: return 1; endcase
  endfunction

  function automatic logic [3:0] lane_mask();
    return (lanes == 4) ? 4'b1111 : (lanes == 2) ? 4'b0011 : 4'b0001;
  endfunction

  task automatic put_bits(input logic [31:0] v, input int nb);
    for (int i = nb; i > 0; i -= lanes) begin
      sdio_i = '0;
      for (int k = 0; k < lanes; k++) sdio_i[k] = v[i-1-k];
      tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
    end
  endtask

  task automatic get_bits(output logic [31:0] v, input int nb, output bit oe_ok);
    v = '0; oe_ok = 1;
    for (int i = nb; i > 0; i -= lanes) begin
      tick(4);
      if (sdio_oe !== lane_mask()) oe_ok = 0;
      for (int k = 0; k < lanes; k++) v = {v[30:0], sdio_o[k]};
      sclk = 1'b1; tick(4); sclk = 1'b0;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] val, input logic [1:0] junk);
    cs_n = 1'b0; tick(2);
    put_bits({24'b0, 1'b0, junk, a}, 8);
    put_bits(val, 8 * nbytes(a));
    tick(2); cs_n = 1'b1; tick(4);
    case (a)
      5'd0: m_cfg = val[7:0];
      5'd1: m_f = val;
      5'd2: m_p = val[15:0];
      5'd3: m_a = val[15:0];
      default: ;
    endcase
    if (a == 5'd0) lanes = val[1] ? 4 : (val[0] ? 2 : 1);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bit ok;
    cs_n = 1'b0; tick(2);
    put_bits({24'b0, 1'b1, 2'b00, a}, 8);
    get_bits(v, 8 * nbytes(a), ok);
    check("R7 lane enables during readback", {31'b0, ok}, 32'd1);
    tick(2);
    check("R9 lanes released after last group", {28'b0, sdio_oe}, 32'd0);
    cs_n = 1'b1; tick(4);
  endtask

  function automatic logic [31:0] model(input logic [4:0] a);
    case (a)
      5'd0: return {24'b0, m_cfg};
      5'd1: return m_f;
      5'd2: return {16'b0, m_p};
      5'd3: return {16'b0, m_a};
      default: return 32'd0;
    endcase
  endfunction

  task automatic pulse_update();
    update = 1'b1; tick(1); update = 1'b0; tick(1);
  endtask

  initial begin
    logic [31:0] v;
    tick(3); rst_n = 1'b1; tick(4);
    check("R1 reset freq", freq_o, 32'd0);
    check("R1 reset phase", {16'b0, phase_o}, 32'd0);
    check("R1 reset amp", {16'b0, amp_o}, 32'd0);
    check("R1 reset lane enables", {28'b0, sdio_oe}, 32'd0);
    rd(5'd0, v);
    check("R1 reset lane mode one lane", v, 32'd0);

    for (int m = 0; m < 3; m++) begin
      wr(5'd0, 32'(m), 2'b00);
      rd(5'd0, v);
      check("R3 lane mode readback", v, 32'(m));
      for (int i = 0; i < 8; i++) begin
        wr(VEC[i][36:32], VEC[i][31:0], 2'b00);
        rd(VEC[i][36:32], v);
        check((VEC[i][36:32] > 3) ? "R10 unmapped reads zero" : "R4 R5 readback in lane mode",
              v, model(VEC[i][36:32]));
      end
      if (m == 0) begin
        check("R6 active freq held before update", freq_o, 32'd0);
        check("R6 active amp held before update", {16'b0, amp_o}, 32'd0);
      end
      pulse_update();
      check("R6 freq after update", freq_o, m_f);
      check("R6 phase after update", {16'b0, phase_o}, {16'b0, m_p});
      check("R6 amp after update", {16'b0, amp_o}, {16'b0, m_a});
    end

    wr(5'd2, 32'h00001357, 2'b11);
    rd(5'd2, v);
    check("R2 bits 6:5 ignored", v, 32'h00001357);
    check("R6 active phase unchanged by write", {16'b0, phase_o}, 32'h00000001);

    cs_n = 1'b0; tick(2);
    put_bits({24'b0, 8'h01}, 8);
    put_bits(32'h00000ABC, 12);
    tick(2); cs_n = 1'b1; tick(4);
    rd(5'd1, v);
    check("R8 aborted write discarded", v, m_f);

    cs_n = 1'b0; tick(2);
    put_bits({24'b0, 8'h81}, 8);
    tick(4); sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    check("R7 read drives after fall", {28'b0, sdio_oe}, 32'hF);
    cs_n = 1'b1; tick(4);
    check("R8 abort releases lanes", {28'b0, sdio_oe}, 32'd0);

    cs_n = 1'b0; tick(2);
    put_bits({24'b0, 8'h00}, 8);
    put_bits(32'h00000002, 8);
    put_bits(32'h00000000, 16);
    tick(2); cs_n = 1'b1; tick(4);
    rd(5'd0, v);
    check("R9 edges after final byte ignored", v, 32'd2);

    put_bits(32'h00000000, 16);
    rd(5'd0, v);
    check("R11 edges ignored while deselected", v, 32'd2);

    wr(5'd0, 32'd3, 2'b00);
    wr(5'd3, 32'h0000C3A5, 2'b00);
    rd(5'd3, v);
    check("R3 mode 11 uses four lanes", v, 32'h0000C3A5);
    wr(5'd0, 32'd1, 2'b00);
    wr(5'd1, 32'h89ABCDEF, 2'b00);
    rd(5'd1, v);
    check("R4 two-lane ordering after mode change", v, 32'h89ABCDEF);
    pulse_update();
    check("R6 final freq after update", freq_o, 32'h89ABCDEF);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule